// File: doc/BRIEF.md
# Command Register Handshake Sequencer

This block is the command word that host software uses to drive a communication co-processor. The host writes one 16-bit word that carries an opcode, a channel number and a busy semaphore bit. If the word is well formed and the semaphore bit is set, the block latches it. It then hands the opcode and channel to an execution engine with a single-cycle issue pulse and keeps the semaphore reading 1 until the engine answers with a done pulse. Software polls the semaphore in the same word it wrote.

A word that also carries the reset bit does not go to the engine. Instead the block holds an engine reset line for a fixed number of cycles, clears its own state and then drops the semaphore. Three sticky status outputs report the faults software cannot see from the semaphore alone:
- a word rejected for reserved bits,
- a write that arrived while a command was still running,
- an engine that never answered within the configured bound.

The sequencer has four named states:
- `SEQ_IDLE`: waiting for a host write.
- `SEQ_ISSUE`: the one cycle in which the issue pulse is driven.
- `SEQ_WAIT`: waiting for done, or for the timeout bound to run out.
- `SEQ_RESET`: the engine reset line is held.

It has six transitions:
- IDLE→ISSUE on an accepted command.
- IDLE→RESET on an accepted reset command.
- ISSUE→WAIT, always.
- WAIT→IDLE on done (complete).
- WAIT→IDLE on bound expiry (timeout).
- RESET→IDLE when the reset count ends.

Top module: `cmd_handshake_seq`

## Requirements
- R1: The readback word holds the reset bit in bit 15, the opcode in bits 11:8, the channel in bits 7:4 and the busy semaphore in bit 0. Bits 14:12 and 3:1 always read 0. After `rst_n` the word reads 0x0000 and all three status outputs are 0.
- R2: A write in SEQ_IDLE with no reserved bit set, bit 0 = 1 and bit 15 = 0 latches opcode and channel and sets busy from the next cycle. In that next cycle (SEQ_ISSUE) `eng_issue` is 1 for exactly one cycle, with `eng_opcode` and `eng_chan` equal to the written fields.
- R3: `eng_done` sampled in SEQ_WAIT clears busy in the following cycle, and opcode and channel are kept. `eng_done` in any other state has no effect.
- R4: A write in SEQ_IDLE with any of bits 14:12 or 3:1 set starts nothing, leaves the readback word unchanged and sets sticky `err_invalid`.
- R5: A valid write in SEQ_IDLE with bit 0 = 0 has no effect on the readback word or the engine outputs.
- R6: Any write while busy reads 1 is ignored and sets sticky `err_overrun`.
- R7: If `eng_done` is not sampled within TMO_LIMIT cycles of SEQ_WAIT, busy clears and sticky `err_timeout` sets. A done in the last allowed cycle still counts as completion.
- R8: A valid write in SEQ_IDLE with bits 15 and 0 both set holds `eng_reset` for RST_CYCLES cycles starting the next cycle, with no issue pulse and busy reading 1. At the end, the readback word is 0x8000 and all status outputs are 0.
- R9: An accepted command write without bit 15 clears the reset bit in the readback word.
- R10: The status outputs stay set until a reset command completes or `rst_n` is asserted. If a flag would be set in the cycle a reset command completes, the clear takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Host write strobe for the command word |
| host_wdata | input | 16 | Command word being written |
| host_rdata | output | 16 | Command word readback, including busy in bit 0 |
| err_invalid | output | 1 | Sticky: a write was rejected for reserved bits |
| err_overrun | output | 1 | Sticky: a write arrived while busy |
| err_timeout | output | 1 | Sticky: the engine did not answer in time |
| eng_issue | output | 1 | One-cycle command start pulse to the engine |
| eng_opcode | output | 4 | Latched opcode presented to the engine |
| eng_chan | output | 4 | Latched channel presented to the engine |
| eng_done | input | 1 | Engine completion pulse |
| eng_reset | output | 1 | Engine reset, held during a reset command |

## Verification
The assertions check the following on every cycle:
- the issue pulse lasts one cycle and coincides with busy;
- busy only rises after a host write;
- issue and engine reset never overlap;
- reserved readback bits stay 0;
- rejected and no-semaphore writes leave the word unchanged;
- sticky flags only fall as a reset command ends, and the word reads 0x8000 at that point.

Only the bench's scenarios can show the rest:
- the exact cycle in which busy falls after done for different engine latencies;
- the timeout boundary, with done in the last allowed cycle and one cycle late;
- a done that arrives in SEQ_IDLE being ignored;
- the reset bit clearing on the next ordinary command.

// File: rtl/cmdseq_pkg.sv
package cmdseq_pkg;

    localparam int WORD_W   = 16;
    localparam int RST_BIT  = 15;
    localparam int BUSY_BIT = 0;
    localparam int OP_LO    = 8;
    localparam int OP_W     = 4;
    localparam int CH_LO    = 4;
    localparam int CH_W     = 4;

    // bits that must be zero in any accepted word: 14:12 and 3:1
    localparam logic [WORD_W-1:0] RSV_MASK = 16'h700E;

    localparam int NUM_FLAGS = 3;
    localparam int FLAG_INV  = 0;
    localparam int FLAG_OVR  = 1;
    localparam int FLAG_TMO  = 2;

    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_ISSUE = 2'd1,
        SEQ_WAIT  = 2'd2,
        SEQ_RESET = 2'd3
    } seq_state_e;

    typedef struct packed {
        logic            ok;
        logic            rst;
        logic [OP_W-1:0] op;
        logic [CH_W-1:0] ch;
        logic            sem;
    } cmd_fields_t;

endpackage

// File: rtl/cmdseq_decode.sv
module cmdseq_decode
    import cmdseq_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output cmd_fields_t       fields
);

    always_comb begin
        fields.ok  = ((word & RSV_MASK) == '0);
        fields.rst = word[RST_BIT];
        fields.op  = word[OP_LO +: OP_W];
        fields.ch  = word[CH_LO +: CH_W];
        fields.sem = word[BUSY_BIT];
    end

endmodule

// File: rtl/cmdseq_timer.sv
module cmdseq_timer #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          clr,
    input  logic [CW-1:0] limit,
    output logic          expire
);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || clr) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expire = run && (cnt_q == (limit - 1'b1));

endmodule

// File: rtl/cmdseq_status.sv
module cmdseq_status #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    input  logic         clr_all,
    output logic [N-1:0] flags
);

    for (genvar i = 0; i < N; i++) begin : g_flag
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                flags[i] <= 1'b0;
            end else if (clr_all) begin
                flags[i] <= 1'b0;
            end else if (set[i]) begin
                flags[i] <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/cmdseq_fsm.sv
module cmdseq_fsm
    import cmdseq_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        host_wr,
    input  cmd_fields_t fields,
    input  logic        done,
    input  logic        expire,
    output seq_state_e  state,
    output logic        issue,
    output logic        eng_rst,
    output logic        tmr_run,
    output logic        tmr_clr,
    output logic        ev_load,
    output logic        ev_complete,
    output logic        ev_timeout,
    output logic        ev_rst_done,
    output logic        ev_invalid,
    output logic        ev_overrun
);

    seq_state_e state_q, state_d;
    logic       accept;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    assign accept = host_wr && fields.ok && fields.sem;

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEQ_IDLE: begin
                if (accept) begin
                    state_d = fields.rst ? SEQ_RESET : SEQ_ISSUE;
                end
            end
            SEQ_ISSUE: begin
                state_d = SEQ_WAIT;
            end
            SEQ_WAIT: begin
                if (done || expire) begin
                    state_d = SEQ_IDLE;
                end
            end
            SEQ_RESET: begin
                if (expire) begin
                    state_d = SEQ_IDLE;
                end
            end
        endcase
    end

    // outputs and events
    always_comb begin
        issue       = 1'b0;
        eng_rst     = 1'b0;
        tmr_run     = 1'b0;
        ev_load     = 1'b0;
        ev_complete = 1'b0;
        ev_timeout  = 1'b0;
        ev_rst_done = 1'b0;
        ev_invalid  = 1'b0;
        ev_overrun  = 1'b0;
        unique case (state_q)
            SEQ_IDLE: begin
                ev_load    = accept;
                ev_invalid = host_wr && !fields.ok;
            end
            SEQ_ISSUE: begin
                issue      = 1'b1;
                ev_overrun = host_wr;
            end
            SEQ_WAIT: begin
                tmr_run     = 1'b1;
                ev_complete = done;
                ev_timeout  = !done && expire;
                ev_overrun  = host_wr;
            end
            SEQ_RESET: begin
                eng_rst     = 1'b1;
                tmr_run     = 1'b1;
                ev_rst_done = expire;
                ev_overrun  = host_wr;
            end
        endcase
    end

    assign tmr_clr = ev_complete || ev_timeout || ev_rst_done;
    assign state   = state_q;

endmodule

// File: rtl/cmd_handshake_seq.sv
module cmd_handshake_seq
    import cmdseq_pkg::*;
#(
    parameter int TMO_LIMIT  = 10000,
    parameter int RST_CYCLES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic [WORD_W-1:0] host_wdata,
    output logic [WORD_W-1:0] host_rdata,
    output logic              err_invalid,
    output logic              err_overrun,
    output logic              err_timeout,
    output logic              eng_issue,
    output logic [OP_W-1:0]   eng_opcode,
    output logic [CH_W-1:0]   eng_chan,
    input  logic              eng_done,
    output logic              eng_reset
);

    localparam int MAXV = (TMO_LIMIT > RST_CYCLES) ? TMO_LIMIT : RST_CYCLES;
    localparam int CW   = $clog2(MAXV + 1);

    cmd_fields_t   fields;
    seq_state_e    state;
    logic          tmr_run, tmr_clr, expire;
    logic          ev_load, ev_complete, ev_timeout, ev_rst_done;
    logic          ev_invalid, ev_overrun;
    logic [CW-1:0] limit;
    logic [NUM_FLAGS-1:0] flag_set, flags;

    logic            rstb_q;
    logic [OP_W-1:0] op_q;
    logic [CH_W-1:0] ch_q;
    logic            busy_q;

    cmdseq_decode u_dec (
        .word   (host_wdata),
        .fields (fields)
    );

    cmdseq_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .host_wr     (host_wr),
        .fields      (fields),
        .done        (eng_done),
        .expire      (expire),
        .state       (state),
        .issue       (eng_issue),
        .eng_rst     (eng_reset),
        .tmr_run     (tmr_run),
        .tmr_clr     (tmr_clr),
        .ev_load     (ev_load),
        .ev_complete (ev_complete),
        .ev_timeout  (ev_timeout),
        .ev_rst_done (ev_rst_done),
        .ev_invalid  (ev_invalid),
        .ev_overrun  (ev_overrun)
    );

    assign limit = (state == SEQ_RESET) ? CW'(RST_CYCLES) : CW'(TMO_LIMIT);

    cmdseq_timer #(.CW(CW)) u_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (tmr_run),
        .clr    (tmr_clr),
        .limit  (limit),
        .expire (expire)
    );

    always_comb begin
        flag_set           = '0;
        flag_set[FLAG_INV] = ev_invalid;
        flag_set[FLAG_OVR] = ev_overrun;
        flag_set[FLAG_TMO] = ev_timeout;
    end

    cmdseq_status #(.N(NUM_FLAGS)) u_sts (
        .clk     (clk),
        .rst_n   (rst_n),
        .set     (flag_set),
        .clr_all (ev_rst_done),
        .flags   (flags)
    );

    // command register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rstb_q <= 1'b0;
            op_q   <= '0;
            ch_q   <= '0;
            busy_q <= 1'b0;
        end else if (ev_load) begin
            rstb_q <= fields.rst;
            op_q   <= fields.op;
            ch_q   <= fields.ch;
            busy_q <= 1'b1;
        end else if (ev_rst_done) begin
            op_q   <= '0;
            ch_q   <= '0;
            busy_q <= 1'b0;
        end else if (ev_complete || ev_timeout) begin
            busy_q <= 1'b0;
        end
    end

    always_comb begin
        host_rdata                  = '0;
        host_rdata[RST_BIT]         = rstb_q;
        host_rdata[OP_LO +: OP_W]   = op_q;
        host_rdata[CH_LO +: CH_W]   = ch_q;
        host_rdata[BUSY_BIT]        = busy_q;
    end

    assign eng_opcode  = op_q;
    assign eng_chan    = ch_q;
    assign err_invalid = flags[FLAG_INV];
    assign err_overrun = flags[FLAG_OVR];
    assign err_timeout = flags[FLAG_TMO];

endmodule

// File: rtl/cmd_handshake_seq_checker.sv
module cmd_handshake_seq_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        host_wr,
    input logic [15:0] host_wdata,
    input logic [15:0] host_rdata,
    input logic        err_invalid,
    input logic        err_overrun,
    input logic        err_timeout,
    input logic        eng_issue,
    input logic        eng_reset
);

    assert_rsv_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rdata & 16'h700E) == 16'h0000);

    assert_issue_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        eng_issue |=> !eng_issue);

    assert_issue_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        eng_issue |-> host_rdata[0]);

    assert_busy_needs_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(host_rdata[0]) |-> $past(host_wr));

    assert_invalid_rejected_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && !host_rdata[0] && ((host_wdata & 16'h700E) != 16'h0000))
        |=> (err_invalid && host_rdata == $past(host_rdata)));

    assert_nosem_noeffect_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && !host_rdata[0] && !host_wdata[0])
        |=> (host_rdata == $past(host_rdata) && !eng_issue && !eng_reset));

    assert_overrun_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_rdata[0] && !eng_reset) |=> err_overrun);

    assert_timeout_frees_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_timeout) |-> !host_rdata[0]);

    assert_no_overlap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(eng_issue && eng_reset));

    assert_reset_exit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(eng_reset) |-> (host_rdata == 16'h8000 && !err_invalid
                              && !err_overrun && !err_timeout));

    assert_inv_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(err_invalid) |-> $past(eng_reset));

    assert_ovr_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(err_overrun) |-> $past(eng_reset));

    assert_tmo_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(err_timeout) |-> $past(eng_reset));

endmodule

bind cmd_handshake_seq cmd_handshake_seq_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .host_wr     (host_wr),
    .host_wdata  (host_wdata),
    .host_rdata  (host_rdata),
    .err_invalid (err_invalid),
    .err_overrun (err_overrun),
    .err_timeout (err_timeout),
    .eng_issue   (eng_issue),
    .eng_reset   (eng_reset)
);

// File: tb/cmd_handshake_seq_test.sv
module cmd_handshake_seq_test;

    localparam int TMO = 20;
    localparam int RST = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr = 1'b0;
    logic [15:0] host_wdata = 16'h0000;
    logic [15:0] host_rdata;
    logic        err_invalid, err_overrun, err_timeout;
    logic        eng_issue, eng_reset;
    logic [3:0]  eng_opcode, eng_chan;
    logic        eng_done;
    logic        eng_pulse = 1'b0;
    logic        stray_done = 1'b0;

    always #2 clk = ~clk;

    assign eng_done = eng_pulse | stray_done;

    cmd_handshake_seq #(.TMO_LIMIT(TMO), .RST_CYCLES(RST)) uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .host_wr     (host_wr),
        .host_wdata  (host_wdata),
        .host_rdata  (host_rdata),
        .err_invalid (err_invalid),
        .err_overrun (err_overrun),
        .err_timeout (err_timeout),
        .eng_issue   (eng_issue),
        .eng_opcode  (eng_opcode),
        .eng_chan    (eng_chan),
        .eng_done    (eng_done),
        .eng_reset   (eng_reset)
    );

    int checks = 0;
    int failures = 0;
    bit cmp_on = 1'b0;
    bit finished = 1'b0;

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // engine stand-in with variable latency; latency 0 means it never answers
    int eng_lat = 1;
    int eng_left = -1;
    always @(negedge clk) begin
        eng_pulse = 1'b0;
        if (eng_reset) begin
            eng_left = -1;
        end else if (eng_issue) begin
            eng_left = (eng_lat > 0) ? eng_lat : -1;
        end
        if (!eng_issue && eng_left > 0) begin
            eng_left = eng_left - 1;
            if (eng_left == 0) begin
                eng_pulse = 1'b1;
                eng_left  = -1;
            end
        end
    end

    // behavioural reference: phase 0 idle, 1 issue, 2 waiting, 3 resetting
    int         m_phase = 0;
    int         m_cnt = 0;
    logic       m_rstb = 0, m_busy = 0, m_inv = 0, m_ovr = 0, m_tmo = 0;
    logic [3:0] m_op = 0, m_ch = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_phase = 0; m_cnt = 0; m_rstb = 0; m_busy = 0;
            m_inv = 0; m_ovr = 0; m_tmo = 0; m_op = 0; m_ch = 0;
        end else begin
            if (m_phase != 0 && host_wr) m_ovr = 1;
            case (m_phase)
                0: if (host_wr) begin
                    if ((host_wdata & 16'h700E) != 0) m_inv = 1;
                    else if (host_wdata[0]) begin
                        m_rstb = host_wdata[15];
                        m_op   = host_wdata[11:8];
                        m_ch   = host_wdata[7:4];
                        m_busy = 1;
                        m_cnt  = 0;
                        m_phase = host_wdata[15] ? 3 : 1;
                    end
                end
                1: begin m_phase = 2; m_cnt = 0; end
                2: begin
                    if (eng_done) begin m_busy = 0; m_phase = 0; end
                    else if (m_cnt == TMO - 1) begin m_tmo = 1; m_busy = 0; m_phase = 0; end
                    else m_cnt++;
                end
                default: begin
                    if (m_cnt == RST - 1) begin
                        m_inv = 0; m_ovr = 0; m_tmo = 0; m_op = 0; m_ch = 0;
                        m_busy = 0; m_phase = 0;
                    end else m_cnt++;
                end
            endcase
        end
    end

    // compare every cycle, away from the active edge
    always @(negedge clk) begin
        if (cmp_on && !finished) begin
            check("R1 readback", host_rdata, {m_rstb, 3'b000, m_op, m_ch, 3'b000, m_busy});
            check("R2 issue", {15'd0, eng_issue}, {15'd0, (m_phase == 1)});
            check("R2 opcode/chan", {8'd0, eng_opcode, eng_chan}, {8'd0, m_op, m_ch});
            check("R8 eng_reset", {15'd0, eng_reset}, {15'd0, (m_phase == 3)});
            check("R4 err_invalid", {15'd0, err_invalid}, {15'd0, m_inv});
            check("R6 err_overrun", {15'd0, err_overrun}, {15'd0, m_ovr});
            check("R7 err_timeout", {15'd0, err_timeout}, {15'd0, m_tmo});
        end
    end

    task automatic wr(input logic [15:0] w);
        @(posedge clk); #1;
        host_wr = 1'b1; host_wdata = w;
        @(posedge clk); #1;
        host_wr = 1'b0; host_wdata = 16'h0000;
    endtask

    task automatic wait_cycles(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic sample_at_negedge();
        @(negedge clk);
    endtask

    task automatic summary();
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=running expected=finished");
        summary();
    end

    initial begin
        wait_cycles(3); #1;
        rst_n = 1'b1;
        sample_at_negedge();
        // R1 reset state
        check("R1 reset word", host_rdata, 16'h0000);
        check("R1 reset flags", {13'd0, err_timeout, err_overrun, err_invalid}, 16'h0000);
        cmp_on = 1'b1;

        // R2/R3 command with latency 3
        eng_lat = 3;
        wr(16'h0351);
        sample_at_negedge();
        check("R2 issue cycle", {7'd0, eng_issue, eng_opcode, eng_chan}, 16'h0135);
        check("R2 busy set", host_rdata, 16'h0351);
        wait_cycles(8);
        sample_at_negedge();
        check("R3 busy cleared", host_rdata, 16'h0350);

        // R3 minimum latency
        eng_lat = 1;
        wr(16'h0FA1);
        wait_cycles(6);
        sample_at_negedge();
        check("R3 fast done", host_rdata, 16'h0FA0);

        // R4 reserved bits rejected
        wr(16'h1001);
        wr(16'h0003);
        sample_at_negedge();
        check("R4 word unchanged", host_rdata, 16'h0FA0);
        check("R4 flag", {15'd0, err_invalid}, 16'h0001);

        // R5 write without semaphore
        wr(16'h0A50);
        wait_cycles(2);
        sample_at_negedge();
        check("R5 no effect", host_rdata, 16'h0FA0);

        // R6 write while busy
        eng_lat = 6;
        wr(16'h0121);
        wr(16'h0341);
        wait_cycles(10);
        sample_at_negedge();
        check("R6 kept first", host_rdata, 16'h0120);
        check("R6 flag", {15'd0, err_overrun}, 16'h0001);

        // R7 done in the last allowed cycle
        eng_lat = TMO;
        wr(16'h0211);
        wait_cycles(TMO + 5);
        sample_at_negedge();
        check("R7 boundary word", host_rdata, 16'h0210);
        check("R7 boundary no timeout", {15'd0, err_timeout}, 16'h0000);

        // R7 one cycle late: timeout, late done lands in idle (R3)
        eng_lat = TMO + 1;
        wr(16'h0231);
        wait_cycles(TMO + 6);
        sample_at_negedge();
        check("R7 timeout word", host_rdata, 16'h0230);
        check("R7 timeout flag", {15'd0, err_timeout}, 16'h0001);

        // R3 stray done while idle
        @(posedge clk); #1; stray_done = 1'b1;
        @(posedge clk); #1; stray_done = 1'b0;
        sample_at_negedge();
        check("R3 stray done", host_rdata, 16'h0230);
        check("R10 flags held", {13'd0, err_timeout, err_overrun, err_invalid}, 16'h0007);

        // R8 reset command, with a write during it (R10)
        wr(16'h8001);
        sample_at_negedge();
        check("R8 reset line", {15'd0, eng_reset}, 16'h0001);
        check("R8 busy during reset", host_rdata, 16'h8001);
        wr(16'h0451);
        wait_cycles(RST + 2);
        sample_at_negedge();
        check("R8 after reset", host_rdata, 16'h8000);
        check("R10 flags cleared", {13'd0, err_timeout, err_overrun, err_invalid}, 16'h0000);

        // R9 ordinary command clears the reset bit
        eng_lat = 2;
        wr(16'h0461);
        wait_cycles(6);
        sample_at_negedge();
        check("R9 reset bit cleared", host_rdata, 16'h0460);

        wait_cycles(2);
        summary();
    end

endmodule